// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the processor-side register file of a four-channel, byte-wide DMA controller. Each channel has a 16-bit base address, current address, base count and current count. The processor reaches them over an 8-bit port. The block also holds a command byte, a mode byte for each channel, a four-bit channel mask and a terminal-count status. A transfer engine elsewhere takes its programming from the block's outputs.

Each 16-bit register has a single byte-wide port. A single low/high byte pointer, shared by all channels, decides which half each access reaches. Software can force the pointer back to the low half at any time. The mode and single-mask writes carry the target channel in the low two bits of the data byte. The programmed count is the number of transfers minus one, so 0x0000 means one transfer and 0xFFFF means 65536 transfers.

Writes take effect on the rising clock edge. Read data is combinational from the present state while the read strobe is high. The side effects of a read, which are the pointer toggle and the clearing of terminal-count flags, take place at the edge that ends the read.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all four mask bits are 1. The command byte, all modes, all address and count registers and the terminal-count flags are 0, and the byte pointer selects the low byte.
- R2: Port offset 2n (n = 0..3) is channel n's address register. Two successive writes store the low byte and then the high byte. Each write updates both the base and the current address to the same value. No other channel changes.
- R3: Port offset 2n+1 is channel n's count register and behaves like R2 for the base and current count. Reading an address or count port returns the current register, low byte first and then high byte.
- R4: The byte pointer is shared by all eight address and count ports. It toggles on every read or write of any of them, so a first access to one channel followed by an access to another channel reaches the second channel's high byte.
- R5: A write of any value to offset 12 forces the byte pointer to the low byte.
- R6: A write to offset 11 stores data bits 7:2 as the mode of the channel in bits 1:0. Bit 4 is auto-initialise. Bits 7:6 = 11 flag the channel as cascade. The modes of the other channels are unchanged.
- R7: A write to offset 10 sets the mask bit of the channel in data bits 1:0 to data bit 2. Data bits 7:3 are ignored.
- R8: A write to offset 14 clears all four mask bits. A write to offset 15 loads the four mask bits from data bits 3:0.
- R9: A write to offset 13 (master clear) sets all mask bits. It also clears the command byte, all modes and all terminal-count flags, and returns the byte pointer to low. Address and count contents are kept.
- R10: A read of offset 8 returns the terminal-count flags in bits 3:0 and the pending requests in bits 7:4. The read clears the flags, but a flag raised by tc_set in the same cycle survives.
- R11: A write to offset 8 stores the command byte and presents it on cmd_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 4 | Register port offset |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| tc_set | input | 4 | Terminal-count pulses from the transfer engine |
| req_pending | input | 4 | Live request lines per channel |
| rd_data | output | 8 | Read data, 0 when rd_en is low |
| cmd_out | output | 8 | Command byte |
| ch_mask | output | 4 | Per-channel mask |
| ch_mode | output | 4x6 | Per-channel mode, data bits 7:2 of the mode write |
| ch_cascade | output | 4 | Channel in cascade mode |
| ch_autoinit | output | 4 | Channel auto-initialise enable |
| base_addr | output | 4x16 | Base address per channel |
| cur_addr | output | 4x16 | Current address per channel |
| base_cnt | output | 4x16 | Base count per channel |
| cur_cnt | output | 4x16 | Current count per channel |

## Verification
Every write is visible on the outputs one clock after its strobe. The bench drives a strobe for exactly one cycle from a falling edge and samples at the next falling edge, which is after the single register stage. Read data is combinational, so the bench samples it 1 ns after raising rd_en, in the same cycle. A read's pointer toggle or flag clear is checked through the next access. Terminal-count pulses are applied for one whole cycle before the status read that should observe them.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int NUM_CH  = 4;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int DATA_W  = 8;
    localparam int REG_W   = 2 * DATA_W;
    localparam int OFS_W   = 4;
    localparam int MODE_W  = DATA_W - CH_W;

    typedef enum logic [OFS_W-1:0] {
        P_CMD_STAT = 4'd8,
        P_MASK_ONE = 4'd10,
        P_MODE     = 4'd11,
        P_CLR_PTR  = 4'd12,
        P_MCLR     = 4'd13,
        P_CLR_MASK = 4'd14,
        P_MASK_ALL = 4'd15
    } ctl_port_e;

    // mode byte bits 7:2
    typedef struct packed {
        logic [1:0] kind;      // 11 = cascade
        logic       decr;
        logic       autoinit;
        logic [1:0] dir;
    } mode_t;

    function automatic logic is_chan_port(input logic [OFS_W-1:0] ofs);
        return !ofs[OFS_W-1];
    endfunction

    function automatic logic [CH_W-1:0] port_chan(input logic [OFS_W-1:0] ofs);
        return ofs[CH_W:1];
    endfunction

    function automatic logic [DATA_W-1:0] pick_byte(input logic [REG_W-1:0] w,
                                                   input logic hi);
        return hi ? w[REG_W-1:DATA_W] : w[DATA_W-1:0];
    endfunction

    function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] w,
                                                 input logic hi,
                                                 input logic [DATA_W-1:0] b);
        return hi ? {b, w[DATA_W-1:0]} : {w[REG_W-1:DATA_W], b};
    endfunction
endpackage

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic toggle,
    output logic byte_hi
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            byte_hi <= 1'b0;
        else if (toggle)
            byte_hi <= !byte_hi;
    end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              byte_hi,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [REG_W-1:0]  base_addr,
    output logic [REG_W-1:0]  cur_addr,
    output logic [REG_W-1:0]  base_cnt,
    output logic [REG_W-1:0]  cur_cnt
);
    logic [REG_W-1:0] addr_nx;
    logic [REG_W-1:0] cnt_nx;

    assign addr_nx = put_byte(base_addr, byte_hi, wr_byte);
    assign cnt_nx  = put_byte(base_cnt, byte_hi, wr_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
        end else begin
            if (wr_addr) begin
                base_addr <= addr_nx;
                cur_addr  <= addr_nx;
            end
            if (wr_cnt) begin
                base_cnt <= cnt_nx;
                cur_cnt  <= cnt_nx;
            end
        end
    end
endmodule

// File: rtl/dmac_ctl_regs.sv
module dmac_ctl_regs
    import dmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mclr,
    input  logic               wr_cmd,
    input  logic               wr_mode,
    input  logic               wr_mask_one,
    input  logic               wr_clr_mask,
    input  logic               wr_mask_all,
    input  logic [DATA_W-1:0]  wr_byte,
    output logic [DATA_W-1:0]  cmd_q,
    output mode_t [NUM_CH-1:0] mode_q,
    output logic [NUM_CH-1:0]  mask_q
);
    logic [CH_W-1:0] sel;
    assign sel = wr_byte[CH_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            cmd_q  <= '0;
            mode_q <= '0;
            mask_q <= '1;
        end else begin
            if (wr_cmd)
                cmd_q <= wr_byte;
            if (wr_mode)
                mode_q[sel] <= mode_t'(wr_byte[DATA_W-1:CH_W]);
            if (wr_mask_one)
                mask_q[sel] <= wr_byte[2];
            else if (wr_clr_mask)
                mask_q <= '0;
            else if (wr_mask_all)
                mask_q <= wr_byte[NUM_CH-1:0];
        end
    end
endmodule

// File: rtl/dmac_status.sv
module dmac_status
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mclr,
    input  logic              rd_clr,
    input  logic [NUM_CH-1:0] tc_set,
    output logic [NUM_CH-1:0] tc_flags
);
    always_ff @(posedge clk) begin
        if (rst || mclr)
            tc_flags <= '0;
        else if (rd_clr)
            tc_flags <= tc_set;
        else
            tc_flags <= tc_flags | tc_set;
    end
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [OFS_W-1:0]              port_sel,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [NUM_CH-1:0]             tc_set,
    input  logic [NUM_CH-1:0]             req_pending,
    output logic [DATA_W-1:0]             rd_data,
    output logic [DATA_W-1:0]             cmd_out,
    output logic [NUM_CH-1:0]             ch_mask,
    output logic [NUM_CH-1:0][MODE_W-1:0] ch_mode,
    output logic [NUM_CH-1:0]             ch_cascade,
    output logic [NUM_CH-1:0]             ch_autoinit,
    output logic [NUM_CH-1:0][REG_W-1:0]  base_addr,
    output logic [NUM_CH-1:0][REG_W-1:0]  cur_addr,
    output logic [NUM_CH-1:0][REG_W-1:0]  base_cnt,
    output logic [NUM_CH-1:0][REG_W-1:0]  cur_cnt
);
    logic              byte_hi;
    logic              chan_acc;
    logic              mclr;
    logic              clr_ptr;
    logic              stat_rd;
    logic [CH_W-1:0]   acc_ch;
    logic [NUM_CH-1:0] tc_flags;
    mode_t [NUM_CH-1:0] mode_q;

    assign acc_ch   = port_chan(port_sel);
    assign chan_acc = (wr_en || rd_en) && is_chan_port(port_sel);
    assign mclr     = wr_en && (port_sel == OFS_W'(P_MCLR));
    assign clr_ptr  = wr_en && (port_sel == OFS_W'(P_CLR_PTR));
    assign stat_rd  = rd_en && !wr_en && (port_sel == OFS_W'(P_CMD_STAT));

    dmac_byte_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .clear   (clr_ptr || mclr),
        .toggle  (chan_acc),
        .byte_hi (byte_hi)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en && is_chan_port(port_sel) && (acc_ch == CH_W'(c));

        dmac_chan_regs u_regs (
            .clk       (clk),
            .rst       (rst),
            .wr_addr   (hit && !port_sel[0]),
            .wr_cnt    (hit && port_sel[0]),
            .byte_hi   (byte_hi),
            .wr_byte   (wr_data),
            .base_addr (base_addr[c]),
            .cur_addr  (cur_addr[c]),
            .base_cnt  (base_cnt[c]),
            .cur_cnt   (cur_cnt[c])
        );

        assign ch_mode[c]     = mode_q[c];
        assign ch_cascade[c]  = (mode_q[c].kind == 2'b11);
        assign ch_autoinit[c] = mode_q[c].autoinit;
    end

    dmac_ctl_regs u_ctl (
        .clk         (clk),
        .rst         (rst),
        .mclr        (mclr),
        .wr_cmd      (wr_en && (port_sel == OFS_W'(P_CMD_STAT))),
        .wr_mode     (wr_en && (port_sel == OFS_W'(P_MODE))),
        .wr_mask_one (wr_en && (port_sel == OFS_W'(P_MASK_ONE))),
        .wr_clr_mask (wr_en && (port_sel == OFS_W'(P_CLR_MASK))),
        .wr_mask_all (wr_en && (port_sel == OFS_W'(P_MASK_ALL))),
        .wr_byte     (wr_data),
        .cmd_q       (cmd_out),
        .mode_q      (mode_q),
        .mask_q      (ch_mask)
    );

    dmac_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .mclr     (mclr),
        .rd_clr   (stat_rd),
        .tc_set   (tc_set),
        .tc_flags (tc_flags)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (is_chan_port(port_sel))
                rd_data = port_sel[0] ? pick_byte(cur_cnt[acc_ch], byte_hi)
                                      : pick_byte(cur_addr[acc_ch], byte_hi);
            else if (port_sel == OFS_W'(P_CMD_STAT))
                rd_data = {req_pending, tc_flags};
        end
    end
endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk
    import dmac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OFS_W-1:0]  port_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic [NUM_CH-1:0] tc_set,
    input logic [NUM_CH-1:0] ch_mask,
    input logic              byte_hi,
    input logic [NUM_CH-1:0] tc_flags
);
    // R9
    mclr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_sel == 4'd13) |=> (ch_mask == '1));

    // R8
    clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_sel == 4'd14) |=> (ch_mask == '0));

    // R8
    all_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_sel == 4'd15) |=> (ch_mask == $past(wr_data[NUM_CH-1:0])));

    // R7
    one_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_sel == 4'd10) |=> (ch_mask[$past(wr_data[CH_W-1:0])] == $past(wr_data[2])));

    // R5
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_sel == 4'd12) |=> !byte_hi);

    // R4
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_en) && !port_sel[OFS_W-1]) |=> (byte_hi != $past(byte_hi)));

    // R10
    tc_read_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && port_sel == 4'd8 && tc_set == '0) |=> (tc_flags == '0));
endmodule

bind dmac_regfile dmac_regfile_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .port_sel (port_sel),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .tc_set   (tc_set),
    .ch_mask  (ch_mask),
    .byte_hi  (byte_hi),
    .tc_flags (tc_flags)
);

// File: tb/dmac_regfile_tb.sv
module dmac_regfile_tb;
    import dmac_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [OFS_W-1:0]  port_sel = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [NUM_CH-1:0] tc_set = '0;
    logic [NUM_CH-1:0] req_pending = '0;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] cmd_out;
    logic [NUM_CH-1:0] ch_mask;
    logic [NUM_CH-1:0][MODE_W-1:0] ch_mode;
    logic [NUM_CH-1:0] ch_cascade;
    logic [NUM_CH-1:0] ch_autoinit;
    logic [NUM_CH-1:0][REG_W-1:0] base_addr, cur_addr, base_cnt, cur_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [REG_W-1:0]  ea [NUM_CH];
    logic [REG_W-1:0]  ec [NUM_CH];
    logic [MODE_W-1:0] em [NUM_CH];
    logic [NUM_CH-1:0] emask;

    always #5 clk = ~clk;

    dmac_regfile u_dut (
        .clk(clk), .rst(rst), .port_sel(port_sel), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .tc_set(tc_set), .req_pending(req_pending),
        .rd_data(rd_data), .cmd_out(cmd_out), .ch_mask(ch_mask), .ch_mode(ch_mode),
        .ch_cascade(ch_cascade), .ch_autoinit(ch_autoinit), .base_addr(base_addr),
        .cur_addr(cur_addr), .base_cnt(base_cnt), .cur_cnt(cur_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next one
    task automatic wr(input int p, input logic [7:0] d);
        port_sel = 4'(p); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int p, output logic [7:0] d);
        port_sel = 4'(p); rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_chans(input string req);
        for (int c = 0; c < NUM_CH; c++) begin
            check(req, base_addr[c], ea[c]);
            check(req, cur_addr[c], ea[c]);
            check(req, base_cnt[c], ec[c]);
            check(req, cur_cnt[c], ec[c]);
        end
    endtask

    task automatic check_modes(input string req);
        for (int c = 0; c < NUM_CH; c++) begin
            check(req, ch_mode[c], em[c]);
            check(req, ch_cascade[c], em[c][5:4] == 2'b11);
            check(req, ch_autoinit[c], em[c][2]);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d0, d1;
        logic [REG_W-1:0] av, cv;
        logic [7:0] mb [6];
        mb = '{8'h44, 8'h48, 8'hC0, 8'h10, 8'h58, 8'hFC};

        for (int c = 0; c < NUM_CH; c++) begin
            ea[c] = '0; ec[c] = '0; em[c] = '0;
        end
        emask = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1", ch_mask, 4'hF);
        check("R1", cmd_out, 0);
        check_modes("R1");
        check_chans("R1");
        rd(8, d);
        check("R1", d, 0);
        wr(0, 8'hAB); ea[0] = 16'h00AB;   // pointer starts low
        check_chans("R1");
        wr(12, 0);

        // R2 / R3 sweep over channels and patterns
        for (int c = 0; c < NUM_CH; c++) begin
            for (int k = 0; k < 6; k++) begin
                av = 16'((c + 1) * 16'h1357 + k * 16'h2F1D);
                cv = av ^ 16'hA5C3;
                if (k == 4) begin av = 16'hFFFF; cv = 16'h0000; end
                if (k == 5) begin av = 16'h0000; cv = 16'hFFFF; end
                wr(12, 8'h5A);
                wr(2 * c, av[7:0]);
                wr(2 * c, av[15:8]);
                wr(2 * c + 1, cv[7:0]);
                wr(2 * c + 1, cv[15:8]);
                ea[c] = av; ec[c] = cv;
                check_chans("R2");
                rd(2 * c, d0); rd(2 * c, d1);
                check("R3", {d1, d0}, av);
                rd(2 * c + 1, d0); rd(2 * c + 1, d1);
                check("R3", {d1, d0}, cv);
            end
        end

        // R4 shared pointer across channels, and toggled by reads
        wr(12, 0);
        wr(0, 8'h11); ea[0][7:0] = 8'h11;
        wr(2, 8'h22); ea[1][15:8] = 8'h22;
        check_chans("R4");
        rd(6, d);
        check("R4", d, ea[3][7:0]);
        wr(6, 8'h5A); ea[3][15:8] = 8'h5A;
        wr(7, 8'h3C); ec[3][7:0] = 8'h3C;
        check_chans("R4");

        // R5 clear pointer mid-sequence
        wr(12, 0);
        wr(4, 8'h77); ea[2][7:0] = 8'h77;
        wr(12, 8'hFF);
        wr(4, 8'h88); ea[2][7:0] = 8'h88;
        check_chans("R5");
        wr(12, 0);

        // R6 mode writes
        for (int c = 0; c < NUM_CH; c++) begin
            for (int i = 0; i < 6; i++) begin
                wr(11, mb[i] | 8'(c));
                em[c] = mb[(i + 0)][7:2];
                check_modes("R6");
            end
            wr(11, mb[c] | 8'(c));
            em[c] = mb[c][7:2];
        end
        check_modes("R6");

        // R7 single-channel mask, upper bits ignored
        for (int c = 0; c < NUM_CH; c++) begin
            for (int v = 0; v < 2; v++) begin
                wr(10, {5'b10110, 1'(v), 2'(c)});
                emask[c] = 1'(v);
                check("R7", ch_mask, emask);
            end
            wr(10, {5'b01001, 1'(c[0]), 2'(c)});
            emask[c] = c[0];
            check("R7", ch_mask, emask);
        end

        // R8 clear-mask and all-mask
        wr(14, 8'hFF);
        check("R8", ch_mask, 0);
        for (int v = 0; v < 16; v++) begin
            wr(15, {4'hC, 4'(v)});
            check("R8", ch_mask, v);
        end

        // R11 command byte
        wr(8, 8'h5C);
        check("R11", cmd_out, 8'h5C);
        wr(8, 8'hA3);
        check("R11", cmd_out, 8'hA3);

        // R10 status read
        req_pending = 4'b1010;
        tc_set = 4'b0101;
        @(negedge clk);
        tc_set = 4'b0000;
        rd(8, d);
        check("R10", d, 8'hA5);
        rd(8, d);
        check("R10", d, 8'hA0);
        tc_set = 4'b0010;
        rd(8, d);
        tc_set = 4'b0000;
        check("R10", d, 8'hA0);
        rd(8, d);
        check("R10", d, 8'hA2);
        rd(8, d);
        check("R10", d, 8'hA0);

        // R9 master clear
        wr(14, 0);
        tc_set = 4'b1000;
        @(negedge clk);
        tc_set = 4'b0000;
        wr(12, 0);
        wr(0, 8'h99); ea[0][7:0] = 8'h99;
        wr(13, 8'h00);
        check("R9", ch_mask, 4'hF);
        check("R9", cmd_out, 0);
        for (int c = 0; c < NUM_CH; c++) em[c] = '0;
        check_modes("R9");
        check_chans("R9");
        rd(8, d);
        check("R9", d, 8'hA0);
        wr(0, 8'h42); ea[0][7:0] = 8'h42;
        check_chans("R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule